// File: doc/BRIEF.md
# Multi-Mode 24-Bit Counter/Timer Channel

This block is one counter/timer channel on a 16-bit register bus. A 24-bit counter takes its count pulses from a quadrature encoder (phases A and B plus an index line) at one, two or four counts per encoder cycle, or from an internal timebase tick. It can also count in a direction that software sets. A single 16-bit mode word chooses the clock source, the direction source, the enable source, the reload behaviour, which preload register takes bus writes, how reads are latched, and the output source and polarity. Command writes clear the counter, load it from preload register 0, or clear the terminal-count flag. Clearing that flag is what starts a one-shot pulse.

The same channel serves as a position counter, a one-shot pulse generator and a pulse-train generator. In pulse-train use the counter counts down and reloads from preload 0, which sets the period. The output is high while the count lies between 1 and preload 1, which sets the width. The period must be greater than the width, and the width must be greater than zero. The bus has no streaming data path. Reads and writes are single-cycle strobes with no back-pressure, and every other pin is a plain level or pulse.

Top module: `cnt_timer_chan`

## Requirements
- R1: After reset the mode word, both preload registers, the counter and the read latch are zero, and the terminal-count flag is 1, so the output pin is 1.
- R2: A write to address 2 stores the mode word, and a read of address 2 returns all 16 bits. The field positions are: bit 0 output source, bit 1 output polarity, bits 4:2 reload select, bits 6:5 hardware enable source, bits 8:7 enable control, bits 10:9 clock source, bit 11 software direction, bit 12 direction control, bit 13 latch control, bit 14 preload select, bit 15 spare.
- R3: A write to address 1 stages bits 7:0 as the upper count byte. A following write to address 0 stores {staged byte, 16-bit data} into preload 1 if mode bit 14 is 1 at that moment, and into preload 0 otherwise.
- R4: A write to address 3 acts on individual bits. Bit 15 clears the counter. Bit 14 loads the counter from preload 0. Bit 3 clears the terminal-count flag. When bits 15 and 14 are both set, the clear wins.
- R5: When latch control is 0, a read of address 0 returns count[15:0] and captures all 24 bits of the count. A read of address 1 returns {8'h00, captured[23:16]}, so a low-then-high pair stays coherent even if the count moves between the two reads.
- R6: When latch control is 1, the latch captures the count on each rising edge of the index input, and addresses 0 and 1 return the latched value.
- R7: Clock source 3 counts every legal Gray-code step of A/B (states 00, 01, 11, 10 in the up order). Clock source 1 counts only the steps where A changes. Clock source 0 counts only the 01 to 11 step upward and the 11 to 01 step downward. A jump of both bits at once is ignored. The counter wraps modulo 2^24.
- R8: When direction control is 0, the decoded quadrature direction sets the count direction. When it is 1, mode bit 11 sets it (1 counts down). Clock source 2 counts once per timebase tick and counts up when direction control is 0.
- R9: Enable control 0 stops counting and enable control 1 runs it. Enable control 2 or 3 takes the hardware source: 0 gate high, 1 gate low, 2 flag set, 3 flag clear.
- R10: A down count from 1 to 0 sets the terminal-count flag, except when reload select is 1.
- R11: With reload select 4, a rising index edge loads the counter from preload 0. With any other reload select, the index edge does not change the count.
- R12: With reload select 1, a down count at value 1 reloads preload 0. With output source 1, the output level is high while 1 <= count <= preload 1.
- R13: With output source 0, the output level is the terminal-count flag. With output polarity 1, the pin is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read-side capture) |
| bus_addr | input | 2 | 0 count low, 1 count high, 2 mode, 3 command |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| tb_tick | input | 1 | Internal timebase pulse, synchronous |
| gate_in | input | 1 | Hardware enable gate, synchronous |
| cnt_out | output | 1 | Counter output pin |

## Verification
A table drives the encoder through forward and reverse Gray sequences in each clock-source mode, and the net counts show which resolution decodes which edges. A run that reverses from zero shows that the counter wraps. Forward steps with a software down direction show that the direction source overrides the decoded direction. A run with enable off leaves the count at zero. Directed sequences cover the following:
- a simultaneous two-bit jump, which must not count;
- a count that rolls across the 16-bit boundary between low and high reads;
- index reloads with reload select 4 and with reload select 0;
- a complete one-shot, in which the count stops at zero;
- a pulse train, in which the reload point and the width threshold both appear at the pin.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef struct packed {
    logic       spare;
    logic       pr_sel;
    logic       latch_ctl;
    logic       dir_ctl;
    logic       dir_down;
    logic [1:0] clk_src;
    logic [1:0] en_ctl;
    logic [1:0] hw_src;
    logic [2:0] reload;
    logic       out_pol;
    logic       out_src;
  } mode_t;

  localparam logic [1:0] CLK_X1 = 2'd0;
  localparam logic [1:0] CLK_X2 = 2'd1;
  localparam logic [1:0] CLK_TB = 2'd2;
  localparam logic [1:0] CLK_X4 = 2'd3;

  localparam logic [2:0] RLD_TRAIN = 3'd1;
  localparam logic [2:0] RLD_INDEX = 3'd4;

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  localparam int CMD_CLR  = 15;
  localparam int CMD_LOAD = 14;
  localparam int CMD_ARM  = 3;

endpackage

// File: rtl/ctr_quad_dec.sv
module ctr_quad_dec #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       idx_in,
  input  logic [1:0] res_sel,
  output logic       step,
  output logic       rev,
  output logic       idx_rise
);
  import ctr_pkg::*;

  logic [SYNC_N-1:0] sa, sb, si;
  logic [1:0] prev_ab;
  logic       prev_i;
  logic [1:0] cur_ab;
  logic       fwd, bwd, a_edge, x1_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0; sb <= '0; si <= '0;
      prev_ab <= 2'b00; prev_i <= 1'b0;
    end else begin
      sa <= {sa[SYNC_N-2:0], a_in};
      sb <= {sb[SYNC_N-2:0], b_in};
      si <= {si[SYNC_N-2:0], idx_in};
      prev_ab <= cur_ab;
      prev_i  <= si[SYNC_N-1];
    end
  end

  assign cur_ab = {sa[SYNC_N-1], sb[SYNC_N-1]};

  always_comb begin
    fwd = ((prev_ab == 2'b00) && (cur_ab == 2'b01)) ||
          ((prev_ab == 2'b01) && (cur_ab == 2'b11)) ||
          ((prev_ab == 2'b11) && (cur_ab == 2'b10)) ||
          ((prev_ab == 2'b10) && (cur_ab == 2'b00));
    bwd = ((prev_ab == 2'b01) && (cur_ab == 2'b00)) ||
          ((prev_ab == 2'b11) && (cur_ab == 2'b01)) ||
          ((prev_ab == 2'b10) && (cur_ab == 2'b11)) ||
          ((prev_ab == 2'b00) && (cur_ab == 2'b10));
    a_edge = prev_ab[1] ^ cur_ab[1];
    x1_hit = (fwd && (prev_ab == 2'b01)) || (bwd && (prev_ab == 2'b11));
    unique case (res_sel)
      CLK_X4:  step = fwd | bwd;
      CLK_X2:  step = (fwd | bwd) & a_edge;
      CLK_X1:  step = x1_hit;
      default: step = 1'b0;
    endcase
  end

  assign rev      = bwd;
  assign idx_rise = si[SYNC_N-1] & ~prev_i;

endmodule

// File: rtl/ctr_core.sv
module ctr_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             run,
  input  logic             clr,
  input  logic             load,
  input  logic             arm,
  input  logic             idx_load,
  input  logic             train,
  input  logic [CNT_W-1:0] pr0,
  output logic [CNT_W-1:0] cnt,
  output logic             tc_flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tc_flag <= 1'b1;
    end else begin
      if (arm) tc_flag <= 1'b0;
      if (clr)            cnt <= '0;
      else if (load)      cnt <= pr0;
      else if (idx_load)  cnt <= pr0;
      else if (run && step) begin
        if (!down)             cnt <= cnt + ONE;
        else if (cnt != ONE)   cnt <= cnt - ONE;
        else if (train)        cnt <= pr0;
        else begin
          cnt <= '0;
          if (!arm) tc_flag <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cnt_timer_chan.sv
module cnt_timer_chan
  import ctr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BUS_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             tb_tick,
  input  logic             gate_in,
  output logic             cnt_out
);
  localparam int HI_W = CNT_W - BUS_W;

  mode_t             mode_q;
  logic [HI_W-1:0]   stage_q;
  logic [CNT_W-1:0]  lat_q, cnt_q, pr0_w, pr1_w;
  logic              rcap_q;
  logic              q_step, q_rev, idx_rise;
  logic              step_sel, down_sel, run, lvl;
  logic              wr_lo, wr_hi, wr_mode, wr_cmd, rd_lo;

  assign wr_lo   = bus_wr && (bus_addr == A_LO);
  assign wr_hi   = bus_wr && (bus_addr == A_HI);
  assign wr_mode = bus_wr && (bus_addr == A_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign rd_lo   = bus_rd && (bus_addr == A_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      stage_q <= '0;
      lat_q   <= '0;
    end else begin
      if (wr_mode) mode_q  <= mode_t'(bus_wdata);
      if (wr_hi)   stage_q <= bus_wdata[HI_W-1:0];
      if (!mode_q.latch_ctl && rd_lo)      lat_q <= cnt_q;
      else if (mode_q.latch_ctl && idx_rise) lat_q <= cnt_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pr
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else if (wr_lo && (mode_q.pr_sel == 1'(g))) val <= {stage_q, bus_wdata};
    end
  end
  assign pr0_w = g_pr[0].val;
  assign pr1_w = g_pr[1].val;

  ctr_quad_dec #(.SYNC_N(SYNC_N)) dec_i (
    .clk(clk), .rst_n(rst_n), .a_in(enc_a), .b_in(enc_b), .idx_in(enc_idx),
    .res_sel(mode_q.clk_src), .step(q_step), .rev(q_rev), .idx_rise(idx_rise)
  );

  always_comb begin
    step_sel = (mode_q.clk_src == CLK_TB) ? tb_tick : q_step;
    if (mode_q.dir_ctl)                 down_sel = mode_q.dir_down;
    else if (mode_q.clk_src == CLK_TB)  down_sel = 1'b0;
    else                                down_sel = q_rev;
    unique case (mode_q.en_ctl)
      2'd0:    run = 1'b0;
      2'd1:    run = 1'b1;
      default: begin
        unique case (mode_q.hw_src)
          2'd0:    run = gate_in;
          2'd1:    run = ~gate_in;
          2'd2:    run = rcap_q;
          default: run = ~rcap_q;
        endcase
      end
    endcase
  end

  ctr_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .step(step_sel), .down(down_sel), .run(run),
    .clr(wr_cmd && bus_wdata[CMD_CLR]), .load(wr_cmd && bus_wdata[CMD_LOAD]),
    .arm(wr_cmd && bus_wdata[CMD_ARM]),
    .idx_load((mode_q.reload == RLD_INDEX) && idx_rise),
    .train(mode_q.reload == RLD_TRAIN), .pr0(pr0_w),
    .cnt(cnt_q), .tc_flag(rcap_q)
  );

  always_comb begin
    unique case (bus_addr)
      A_LO:    bus_rdata = mode_q.latch_ctl ? lat_q[BUS_W-1:0] : cnt_q[BUS_W-1:0];
      A_HI:    bus_rdata = {{(BUS_W-HI_W){1'b0}}, lat_q[CNT_W-1:BUS_W]};
      A_MODE:  bus_rdata = mode_q;
      default: bus_rdata = '0;
    endcase
  end

  assign lvl     = mode_q.out_src ? ((cnt_q != '0) && (cnt_q <= pr1_w)) : rcap_q;
  assign cnt_out = lvl ^ mode_q.out_pol;

endmodule

// File: rtl/cnt_timer_chan_chk.sv
module cnt_timer_chan_chk #(
  parameter int CNT_W = 24,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] mode_bits,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] pr0,
  input logic             tc
);
  logic cmd_w;
  assign cmd_w = bus_wr && (bus_addr == 2'd3);

  // R4
  clr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[15]) |=> (cnt == '0));

  // R4
  load_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[14] && !bus_wdata[15]) |=> (cnt == $past(pr0)));

  // R4
  arm_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[3]) |=> !tc);

  // R10
  tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> (cnt == '0));

  // R9
  halt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_bits[8:7] == 2'd0) && (mode_bits[4:2] != 3'd4) && !cmd_w) |=> $stable(cnt));

  // R2
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 2'd2)) |=> (mode_bits == $past(bus_wdata)));

endmodule

bind cnt_timer_chan cnt_timer_chan_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mode_bits(mode_q), .cnt(cnt_q), .pr0(pr0_w), .tc(rcap_q)
);

// File: tb/cnt_timer_chan_tb_top.sv
module cnt_timer_chan_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic enc_a = 0, enc_b = 0, enc_idx = 0, tb_tick = 0, gate_in = 0;
  logic cnt_out;
  int total = 0, bad = 0, phase = 0;

  always #(CLK_P/2) clk = ~clk;

  cnt_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .tb_tick(tb_tick), .gate_in(gate_in), .cnt_out(cnt_out)
  );

  // {mode, forward steps, reverse steps, expected count}
  localparam logic [55:0] VEC [7] = '{
    {16'h0680, 8'd8, 8'd4, 24'h000004},   // R7 x4
    {16'h0280, 8'd8, 8'd4, 24'h000002},   // R7 x2
    {16'h0080, 8'd8, 8'd4, 24'h000001},   // R7 x1
    {16'h0080, 8'd0, 8'd4, 24'hFFFFFF},   // R7 wrap
    {16'h1E80, 8'd4, 8'd0, 24'hFFFFFC},   // R8 software down
    {16'h1680, 8'd0, 8'd4, 24'h000004},   // R8 software up
    {16'h0600, 8'd4, 8'd0, 24'h000000}    // R9 disabled
  };

  task automatic check_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic read24(output logic [23:0] v);
    logic [15:0] lo, hi;
    bus_read(2'd0, lo);
    bus_read(2'd1, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic set_pr(input logic [23:0] v);
    bus_write(2'd1, {8'h00, v[23:16]});
    bus_write(2'd0, v[15:0]);
  endtask

  task automatic tick();
    @(negedge clk); tb_tick = 1;
    @(negedge clk); tb_tick = 0;
  endtask

  task automatic quad(input bit fwd);
    logic [1:0] ab;
    phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
    case (phase)
      0: ab = 2'b00; 1: ab = 2'b01; 2: ab = 2'b11; default: ab = 2'b10;
    endcase
    @(negedge clk); enc_a = ab[1]; enc_b = ab[0];
    repeat (3) @(negedge clk);
  endtask

  task automatic idx_pulse();
    @(negedge clk); enc_idx = 1;
    repeat (3) @(negedge clk); enc_idx = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r16;
    logic [23:0] r24;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd2, r16); check_eq("R1 mode", r16, 16'h0000);
    read24(r24);         check_eq("R1 count", r24, 24'h0);
    check_eq("R1 out", cnt_out, 1'b1);

    // R7 R8 R9 table walk
    for (int i = 0; i < 7; i++) begin
      bus_write(2'd2, VEC[i][55:40]);
      bus_write(2'd3, 16'h8000);
      for (int f = 0; f < int'(VEC[i][39:32]); f++) quad(1'b1);
      for (int r = 0; r < int'(VEC[i][31:24]); r++) quad(1'b0);
      read24(r24);
      check_eq($sformatf("R7/R8/R9 vector %0d", i), r24, VEC[i][23:0]);
    end

    // R7 illegal two-bit jump
    bus_write(2'd2, 16'h0680); bus_write(2'd3, 16'h8000);
    @(negedge clk); enc_a = 1; enc_b = 1; repeat (4) @(negedge clk);
    enc_a = 0; enc_b = 0; repeat (4) @(negedge clk);
    read24(r24); check_eq("R7 illegal jump", r24, 24'h0);

    // R2 mode readback
    bus_write(2'd2, 16'hA5C3); bus_read(2'd2, r16); check_eq("R2 readback", r16, 16'hA5C3);

    // R3 R4 preload and load, clear wins
    bus_write(2'd2, 16'h0000);
    set_pr(24'h123456); bus_write(2'd3, 16'h4000);
    read24(r24); check_eq("R3 R4 load PR0", r24, 24'h123456);
    bus_write(2'd3, 16'hC000);
    read24(r24); check_eq("R4 clear over load", r24, 24'h0);

    // R5 coherent latch across 16-bit roll
    bus_write(2'd2, 16'h1480);
    set_pr(24'h00FFFF); bus_write(2'd3, 16'h4000);
    bus_read(2'd0, r16); check_eq("R5 low", r16, 16'hFFFF);
    tick();
    bus_read(2'd1, r16); check_eq("R5 high held", r16, 16'h0000);
    read24(r24); check_eq("R5 R8 after tick", r24, 24'h010000);

    // R6 index latch
    bus_write(2'd2, 16'h3480); bus_write(2'd3, 16'h8000);
    tick(); tick(); idx_pulse(); tick();
    read24(r24); check_eq("R6 index latch", r24, 24'h000002);

    // R11 index reload
    bus_write(2'd2, 16'h1490); set_pr(24'h000100); bus_write(2'd3, 16'h8000);
    tick(); tick(); tick(); idx_pulse();
    read24(r24); check_eq("R11 index reload", r24, 24'h000100);
    bus_write(2'd2, 16'h1480); bus_write(2'd3, 16'h8000);
    tick(); idx_pulse();
    read24(r24); check_eq("R11 index ignored", r24, 24'h000001);

    // R9 gate source
    bus_write(2'd2, 16'h1500); bus_write(2'd3, 16'h8000);
    gate_in = 0; tick();
    read24(r24); check_eq("R9 gate low", r24, 24'h0);
    gate_in = 1; tick();
    read24(r24); check_eq("R9 gate high", r24, 24'h1);
    gate_in = 0;

    // R10 R13 one-shot
    bus_write(2'd2, 16'h1D62); set_pr(24'h000003); bus_write(2'd3, 16'h4000);
    @(negedge clk); check_eq("R13 inverted idle", cnt_out, 1'b0);
    bus_write(2'd3, 16'h0008);
    @(negedge clk); check_eq("R10 fired", cnt_out, 1'b1);
    tick(); tick();
    read24(r24); check_eq("R10 mid count", r24, 24'h1);
    check_eq("R10 pulse high", cnt_out, 1'b1);
    tick();
    @(negedge clk); check_eq("R10 pulse end", cnt_out, 1'b0);
    tick();
    read24(r24); check_eq("R9 R10 stopped", r24, 24'h0);

    // R12 R3 pulse train: period 5, width 2
    bus_write(2'd2, 16'h1C85); set_pr(24'h000005);
    bus_write(2'd2, 16'h5C85); set_pr(24'h000002);
    bus_write(2'd2, 16'h1C85); bus_write(2'd3, 16'h4000);
    @(negedge clk); check_eq("R12 start", cnt_out, 1'b0);
    begin
      logic exp_o [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      for (int k = 0; k < 6; k++) begin
        tick();
        #1 check_eq($sformatf("R12 train tick %0d", k), cnt_out, exp_o[k]);
      end
    end
    read24(r24); check_eq("R12 reload", r24, 24'h000004);
    bus_write(2'd2, 16'h1C87);
    @(negedge clk); check_eq("R13 train inverted", cnt_out, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule